// File: doc/BRIEF.md
# Four-Channel Phase-Accumulator Square-Wave Generator

This block produces several independent square waves, each with a 50% duty cycle. A tick strobe from outside paces all channels. Each channel has its own step word and its own phase register. On a tick, every enabled channel adds its step to its phase register, all in the same clock. When an addition carries out of the top bit, that channel's output inverts.

Because an output inverts once per wrap of the register, one full output period takes two wraps. The output frequency is therefore the tick rate times the step, divided by 2^(ACC_W+1). With the default width of 24 bits, that divisor is 2^25.

Each channel has its own enable bit. A disabled channel drives its output low and holds its phase at zero. When it is enabled again, it starts from a known phase. Generating the tick and working out the step words are left to the surrounding logic.

Top module: `sqwave_bank`

## Requirements
- R1: While `rst` is high at a clock edge, every phase register is cleared and every bit of `wave_o` is 0 after that edge.
- R2: On a clock edge where `tick_i` is 1 and a channel's enable is 1, that channel's phase register becomes (phase + step) modulo 2^ACC_W. Channel i's step is `step_i[i*ACC_W +: ACC_W]`.
- R3: A channel's output bit inverts at exactly those edges where its R2 addition carries out of bit ACC_W-1. This gives an output frequency of tick rate × step / 2^(ACC_W+1) at 50% duty.
- R4: On an edge where `tick_i` is 0, no enabled channel changes its phase or its output.
- R5: On an edge where a channel's enable is 0, its output becomes 0 and its phase becomes 0. After re-enabling, the channel counts from zero phase.
- R6: A new step value takes effect on the next tick. The phase register is not cleared, so the phase stays continuous.
- R7: All channels advance on the same tick, each by its own step, with no effect on one another.
- R8: An enabled channel with a step of 0 never changes its output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | Advance strobe, one clock wide per tick |
| step_i | input | NUM_CH*ACC_W | Step words; channel i occupies bits [i*ACC_W +: ACC_W] |
| en_i | input | NUM_CH | Per-channel enable, bit i for channel i |
| wave_o | output | NUM_CH | Registered square-wave outputs, bit i for channel i |

## Verification
The hardest case to reach from the ports is a step change that lands while the phase register holds a large, partly accumulated value. Only then does R6's continuity decide whether the next carry arrives early or late. The stimulus runs each channel with a random step for many ticks and changes the step without dropping the enable. This lets arbitrary residual phase build up first. Near-maximum steps, which carry on almost every tick, are mixed in, together with enable drops that occur in the middle of a period.

// File: rtl/sqw_pkg.sv
package sqw_pkg;
  localparam int unsigned DEF_CH    = 4;
  localparam int unsigned DEF_ACC_W = 24;

  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_CLEAR = 2'd1,
    ACT_STEP  = 2'd2
  } ch_action_e;

  function automatic ch_action_e pick_action(input logic enable, input logic tick);
    if (!enable)   return ACT_CLEAR;
    else if (tick) return ACT_STEP;
    else           return ACT_HOLD;
  endfunction
endpackage

// File: rtl/phase_acc.sv
module phase_acc #(
  parameter int unsigned ACC_W = 24
) (
  input  logic                 clk,
  input  logic                 rst,
  input  sqw_pkg::ch_action_e  act_i,
  input  logic [ACC_W-1:0]     step_i,
  output logic                 wrap_o
);
  logic [ACC_W-1:0] phase_q;
  logic [ACC_W:0]   sum;

  // Carry bit of the sum marks a wrap of the phase register.
  assign sum    = {1'b0, phase_q} + {1'b0, step_i};
  assign wrap_o = (act_i == sqw_pkg::ACT_STEP) && sum[ACC_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
    end else begin
      case (act_i)
        sqw_pkg::ACT_CLEAR: phase_q <= '0;
        sqw_pkg::ACT_STEP:  phase_q <= sum[ACC_W-1:0];
        default:            phase_q <= phase_q;
      endcase
    end
  end
endmodule

// File: rtl/toggle_out.sv
module toggle_out (
  input  logic clk,
  input  logic rst,
  input  logic clear_i,
  input  logic flip_i,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (rst || clear_i) q_o <= 1'b0;
    else if (flip_i)    q_o <= ~q_o;
  end
endmodule

// File: rtl/sqwave_bank.sv
module sqwave_bank #(
  parameter int unsigned NUM_CH = sqw_pkg::DEF_CH,
  parameter int unsigned ACC_W  = sqw_pkg::DEF_ACC_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    tick_i,
  input  logic [NUM_CH*ACC_W-1:0] step_i,
  input  logic [NUM_CH-1:0]       en_i,
  output logic [NUM_CH-1:0]       wave_o
);
  localparam int unsigned STEP_BITS = NUM_CH * ACC_W;

  logic [NUM_CH-1:0] wrap;
  logic [NUM_CH-1:0] clr;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    sqw_pkg::ch_action_e act;
    assign act    = sqw_pkg::pick_action(en_i[g], tick_i);
    assign clr[g] = (act == sqw_pkg::ACT_CLEAR);

    phase_acc #(.ACC_W(ACC_W)) u_acc (
      .clk    (clk),
      .rst    (rst),
      .act_i  (act),
      .step_i (step_i[g*ACC_W +: ACC_W]),
      .wrap_o (wrap[g])
    );

    toggle_out u_tog (
      .clk     (clk),
      .rst     (rst),
      .clear_i (clr[g]),
      .flip_i  (wrap[g]),
      .q_o     (wave_o[g])
    );
  end

  if (STEP_BITS == 0) begin : g_bad
    initial $error("sqwave_bank: empty step bus");
  end
endmodule

// File: rtl/sqwave_bank_chk.sv
module sqwave_bank_chk #(
  parameter int unsigned NUM_CH = sqw_pkg::DEF_CH,
  parameter int unsigned ACC_W  = sqw_pkg::DEF_ACC_W
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    tick_i,
  input logic [NUM_CH*ACC_W-1:0] step_i,
  input logic [NUM_CH-1:0]       en_i,
  input logic [NUM_CH-1:0]       wave_o
);
  a_r1_reset_low: assert property (@(posedge clk) rst |=> (wave_o == '0));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    a_r5_disabled_low: assert property (@(posedge clk) disable iff (rst)
      !en_i[g] |=> !wave_o[g]);
    a_r4_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
      (en_i[g] && !tick_i) |=> $stable(wave_o[g]));
    a_r8_zero_step_holds: assert property (@(posedge clk) disable iff (rst)
      (en_i[g] && tick_i && step_i[g*ACC_W +: ACC_W] == '0) |=> $stable(wave_o[g]));
    a_r3_rise_needs_tick: assert property (@(posedge clk) disable iff (rst)
      $rose(wave_o[g]) |-> ($past(tick_i) && $past(en_i[g])));
  end
endmodule

bind sqwave_bank sqwave_bank_chk #(.NUM_CH(NUM_CH), .ACC_W(ACC_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .tick_i (tick_i),
  .step_i (step_i),
  .en_i   (en_i),
  .wave_o (wave_o)
);

// File: tb/sqwave_bank_tb.sv
module sqwave_bank_tb;
  localparam int CLK_P  = 10;
  localparam int NCH    = 4;
  localparam int AW     = 24;
  localparam int MAXCYC = 200000;

  logic              clk = 1'b0;
  logic              rst;
  logic              tick;
  logic [NCH*AW-1:0] step;
  logic [NCH-1:0]    en;
  logic [NCH-1:0]    wave;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 0;
  string tag = "R1";

  logic [AW-1:0] m_acc [NCH];
  logic          m_out [NCH];

  always #(CLK_P/2) clk = ~clk;

  sqwave_bank #(.NUM_CH(NCH), .ACC_W(AW)) u_dut (
    .clk(clk), .rst(rst), .tick_i(tick), .step_i(step), .en_i(en), .wave_o(wave)
  );

  function automatic logic [AW:0] add_step(input logic [AW-1:0] a, input logic [AW-1:0] s);
    return {1'b0, a} + {1'b0, s};
  endfunction

  task automatic model_edge();
    for (int i = 0; i < NCH; i++) begin
      logic [AW:0] s;
      if (rst || !en[i]) begin
        m_acc[i] = '0;
        m_out[i] = 1'b0;
      end else if (tick) begin
        s = add_step(m_acc[i], step[i*AW +: AW]);
        m_acc[i] = s[AW-1:0];
        if (s[AW]) m_out[i] = ~m_out[i];
      end
    end
  endtask

  task automatic compare();
    for (int i = 0; i < NCH; i++) begin
      checks++;
      if (wave[i] !== m_out[i]) begin
        errors++;
        $display("FAIL %s ch%0d cycle %0d actual %b expected %b", tag, i, cycles, wave[i], m_out[i]);
      end
    end
  endtask

  // Inputs are already set; run one edge, then compare a moment later.
  task automatic cyc();
    @(posedge clk);
    model_edge();
    #1;
    cycles++;
    compare();
  endtask

  task automatic set_step(input int ch, input logic [AW-1:0] v);
    step[ch*AW +: AW] = v;
  endtask

  initial begin
    void'($urandom(32'h5EED));
    rst = 1'b1; tick = 1'b0; step = '0; en = '0;
    for (int i = 0; i < NCH; i++) begin m_acc[i] = '0; m_out[i] = 1'b0; end
    #1;
    tag = "R1";
    en = '1; tick = 1'b1;
    for (int i = 0; i < NCH; i++) set_step(i, 24'hFFFFFF);
    repeat (3) cyc();
    rst = 1'b0;

    // R7 and R3: distinct steps on every channel, tick on each clock.
    tag = "R7";
    set_step(0, 24'h800000); set_step(1, 24'h400000);
    set_step(2, 24'h200000); set_step(3, 24'hFFFFFF);
    repeat (64) cyc();

    // R3: a step of 2^22 toggles every 4 ticks.
    tag = "R3";
    repeat (40) cyc();

    // R4: tick held low.
    tag = "R4";
    tick = 1'b0;
    repeat (20) cyc();

    // R8: zero step.
    tag = "R8";
    tick = 1'b1;
    set_step(1, '0);
    repeat (20) cyc();

    // R5: drop channel 2 mid-period, then bring it back.
    tag = "R5";
    set_step(1, 24'h555555);
    repeat (3) cyc();
    en[2] = 1'b0;
    repeat (5) cyc();
    en[2] = 1'b1;
    repeat (30) cyc();

    // R6: change step with residual phase, enable held.
    tag = "R6";
    set_step(0, 24'h123456);
    repeat (17) cyc();
    set_step(0, 24'hF00001);
    repeat (17) cyc();

    // R2: random steps, sparse ticks, occasional enable drops.
    tag = "R2";
    for (int n = 0; n < 4000; n++) begin
      tick = ($urandom_range(0, 2) != 0);
      if ($urandom_range(0, 63) == 0) en[$urandom_range(0, NCH-1)] = ~en[$urandom_range(0, NCH-1)];
      if ($urandom_range(0, 31) == 0) set_step($urandom_range(0, NCH-1), AW'($urandom()));
      if ($urandom_range(0, 200) == 0) en = '1;
      cyc();
    end

    // R1: reset in the middle of activity.
    tag = "R1";
    rst = 1'b1;
    cyc();
    rst = 1'b0;
    repeat (10) cyc();

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * MAXCYC);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule